// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Timer

This block chooses the clock cycle in which the power switch of a quasi-resonant flyback converter is turned on again. It watches digitized comparator flags taken from the auxiliary-winding (sync) voltage, a flag telling whether the feedback level is above the valley-alternation level, the present gate state, and the on-time of the last pulse in clock cycles. Its one result is a single-cycle turn-on request, which the gate driver acts on.

Each switching cycle begins at a rising edge of the gate. A blanking interval follows, during which no request can be made. After blanking the block either escapes at once (the sync voltage is still high at the end of blanking and no valley has ever been seen during blanking), or searches a limited window for a resonant valley and asks for turn-on a fixed delay after it, or forces turn-on when the window runs out. When the on-time is short and the feedback level is high, valley alternation is active: pairs of first-valley cycles alternate with pairs of second-valley cycles, which spreads the switching frequency. All times are parameters counted in system clock cycles; the defaults suit a 50 MHz clock.

Top module: `qrv_timer`

## Requirements
- R1: While reset is asserted `turn_on` is 0, and after reset the block behaves as if a gate rising edge had been seen on the last reset edge.
- R2: No `turn_on` occurs within the first `BLANK_CYC` clock edges after a gate rising edge.
- R3: If the search window of `WIN_CYC` edges after blanking holds no qualifying valley, `turn_on` is raised right after edge `BLANK_CYC + WIN_CYC` counted from the gate rising edge.
- R4: A valley is an edge at which `sync_above_lo` is 0 while the detector is armed; the detector is armed by any edge with `sync_above_hi` = 1 and disarmed by a valley. After the qualifying valley `turn_on` rises right after the `VALLEY_DLY`-th following edge.
- R5: If at the last blanking edge `sync_above_flat` is 1 and no valley has ever fallen inside blanking, `turn_on` rises right after edge `BLANK_CYC + ESC_DLY` from the gate rising edge, with no valley search.
- R6: Once a valley has been seen inside blanking, the escape of R5 is never taken again until reset; the window search is used instead.
- R7: Alternation is enabled for a cycle only if, at its gate rising edge, `ton_cycles` < `TON_LIM` and `fb_above_avs` = 1; when disabled the cycle uses the first valley after blanking.
- R8: With alternation enabled on consecutive cycles, the qualifying valley follows the pattern first, first, second, second, repeating (second means the second valley after blanking).
- R9: A cycle with alternation disabled restarts the pair pattern, so the next enabled cycle is the first of a first-valley pair.
- R10: `turn_on` is a single-cycle pulse, and at most one is issued between two gate rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_on | input | 1 | Present gate state; a rising edge starts a switching cycle |
| ton_cycles | input | TON_W | Measured on-time of the switch, in clock cycles |
| fb_above_avs | input | 1 | Feedback level above the alternation threshold |
| sync_above_hi | input | 1 | Sync voltage above the upper valley threshold |
| sync_above_lo | input | 1 | Sync voltage above the lower valley threshold |
| sync_above_flat | input | 1 | Sync voltage above the heavy-load plateau level |
| turn_on | output | 1 | Single-cycle turn-on request |

## Verification
The assertions take for granted that a new gate rising edge only follows a turn-on request, so that the cycle age never runs past the latest legal request point before the next cycle starts, and that the comparator flags are already synchronous to the clock. The bench keeps within this by producing the gate pulse itself, a few cycles long, only in response to `turn_on`, and by driving all flags on the falling clock edge. Sync waveforms are a quiet level, a flat plateau and a periodic ringing whose valleys fall both inside blanking and inside the search window, so every path to a request is taken.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

    // phase of one switching cycle, counted from the gate rising edge
    typedef enum logic [1:0] {
        PH_BLANK = 2'd0,
        PH_SEEK  = 2'd1,
        PH_DELAY = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qrv_valley_det.sv
module qrv_valley_det (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic above_lo,
    output logic valley
);

    typedef struct packed {
        logic armed;
    } det_s;

    det_s det_d, det_q;

    always_comb begin
        det_d  = det_q;
        valley = det_q.armed && !above_lo;
        if (above_hi) begin
            det_d.armed = 1'b1;
        end else if (valley) begin
            det_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/qrv_pair_sel.sv
module qrv_pair_sel #(
    parameter int TON_W    = 12,
    parameter int TON_LIM  = 200,
    parameter int PAIR_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [TON_W-1:0] ton_cycles,
    input  logic             fb_high,
    output logic             second
);

    localparam int CNT_W = $clog2(2 * PAIR_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * PAIR_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(PAIR_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             second;
    } sel_s;

    sel_s sel_d, sel_q;
    logic avs_en;

    always_comb begin
        sel_d  = sel_q;
        avs_en = fb_high && (ton_cycles < TON_W'(TON_LIM));
        if (rise) begin
            sel_d.second = avs_en && (sel_q.cnt >= CNT_HALF);
            if (!avs_en) begin
                sel_d.cnt = '0;
            end else if (sel_q.cnt == CNT_LAST) begin
                sel_d.cnt = '0;
            end else begin
                sel_d.cnt = sel_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign second = sel_q.second;

    // R9: a disabled cycle leaves the pair counter at its start
    p_pair_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !fb_high) |=> (sel_q.cnt == '0 && !second));

endmodule

// File: rtl/qrv_seq.sv
module qrv_seq
    import qrv_pkg::*;
#(
    parameter int BLANK_CYC  = 750,
    parameter int WIN_CYC    = 300,
    parameter int VALLEY_DLY = 12,
    parameter int ESC_DLY    = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic valley,
    input  logic flat,
    input  logic second,
    output logic turn_on
);

    localparam int T_ALL = imax(imax(BLANK_CYC, WIN_CYC), imax(VALLEY_DLY, ESC_DLY));
    localparam int TMR_W = $clog2(T_ALL + 1);
    localparam logic [TMR_W-1:0] BLANK_END  = TMR_W'(BLANK_CYC - 1);
    localparam logic [TMR_W-1:0] WIN_END    = TMR_W'(WIN_CYC - 1);
    localparam logic [TMR_W-1:0] VALLEY_END = TMR_W'(VALLEY_DLY - 1);
    localparam logic [TMR_W-1:0] ESC_END    = TMR_W'(ESC_DLY - 1);

    typedef struct packed {
        phase_e           phase;
        logic [TMR_W-1:0] tmr;
        logic [TMR_W-1:0] lim;
        logic [1:0]       need;
        logic             locked;
        logic             fire;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.fire = 1'b0;
        if (rise) begin
            seq_d.phase = PH_BLANK;
            seq_d.tmr   = '0;
        end else begin
            unique case (seq_q.phase)
                PH_BLANK: begin
                    if (valley) begin
                        seq_d.locked = 1'b1;
                    end
                    if (seq_q.tmr == BLANK_END) begin
                        seq_d.tmr = '0;
                        if (!seq_d.locked && flat) begin
                            seq_d.phase = PH_DELAY;
                            seq_d.lim   = ESC_END;
                        end else begin
                            seq_d.phase = PH_SEEK;
                            seq_d.need  = second ? 2'd2 : 2'd1;
                        end
                    end else begin
                        seq_d.tmr = seq_q.tmr + 1'b1;
                    end
                end
                PH_SEEK: begin
                    if (valley && seq_q.need == 2'd1) begin
                        seq_d.phase = PH_DELAY;
                        seq_d.tmr   = '0;
                        seq_d.lim   = VALLEY_END;
                    end else begin
                        if (valley) begin
                            seq_d.need = seq_q.need - 1'b1;
                        end
                        if (seq_q.tmr == WIN_END) begin
                            seq_d.fire  = 1'b1;
                            seq_d.phase = PH_HOLD;
                        end else begin
                            seq_d.tmr = seq_q.tmr + 1'b1;
                        end
                    end
                end
                PH_DELAY: begin
                    if (seq_q.tmr == seq_q.lim) begin
                        seq_d.fire  = 1'b1;
                        seq_d.phase = PH_HOLD;
                    end else begin
                        seq_d.tmr = seq_q.tmr + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.phase  <= PH_BLANK;
            seq_q.need   <= 2'd1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign turn_on = seq_q.fire;

    // R6: the blanking-valley lock never clears outside reset
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.locked |=> seq_q.locked);

endmodule

// File: rtl/qrv_timer.sv
module qrv_timer
    import qrv_pkg::*;
#(
    parameter int TON_W      = 12,
    parameter int BLANK_CYC  = 750,
    parameter int WIN_CYC    = 300,
    parameter int VALLEY_DLY = 12,
    parameter int ESC_DLY    = 25,
    parameter int TON_LIM    = 200,
    parameter int PAIR_LEN   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_on,
    input  logic [TON_W-1:0] ton_cycles,
    input  logic             fb_above_avs,
    input  logic             sync_above_hi,
    input  logic             sync_above_lo,
    input  logic             sync_above_flat,
    output logic             turn_on
);

    typedef struct packed {
        logic gate;
    } top_s;

    top_s top_d, top_q;
    logic rise;
    logic valley;
    logic second;

    always_comb begin
        top_d      = top_q;
        top_d.gate = gate_on;
        rise       = gate_on && !top_q.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    qrv_valley_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .above_hi (sync_above_hi),
        .above_lo (sync_above_lo),
        .valley   (valley)
    );

    qrv_pair_sel #(
        .TON_W    (TON_W),
        .TON_LIM  (TON_LIM),
        .PAIR_LEN (PAIR_LEN)
    ) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .ton_cycles (ton_cycles),
        .fb_high    (fb_above_avs),
        .second     (second)
    );

    qrv_seq #(
        .BLANK_CYC  (BLANK_CYC),
        .WIN_CYC    (WIN_CYC),
        .VALLEY_DLY (VALLEY_DLY),
        .ESC_DLY    (ESC_DLY)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .valley  (valley),
        .flat    (sync_above_flat),
        .second  (second),
        .turn_on (turn_on)
    );

    // ---------------- checking: cycle age and request history ----------------
    localparam int LATEST = BLANK_CYC + WIN_CYC + imax(VALLEY_DLY, ESC_DLY);
    localparam int AGE_W  = $clog2(LATEST + 2);
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(LATEST + 1);

    logic [AGE_W-1:0] age_q;
    logic             fired_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q   <= '0;
            fired_q <= 1'b0;
        end else if (rise) begin
            age_q   <= '0;
            fired_q <= 1'b0;
        end else begin
            age_q   <= (age_q == AGE_SAT) ? age_q : age_q + 1'b1;
            fired_q <= fired_q || turn_on;
        end
    end

    p_blank_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |-> (age_q > AGE_W'(BLANK_CYC)));

    p_latest_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |-> (age_q <= AGE_W'(LATEST)));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |=> !turn_on);

    p_once_per_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |-> !fired_q);

endmodule

// File: tb/qrv_timer_bench.sv
module qrv_timer_bench;

    localparam int TON_W = 12;
    localparam int BLK   = 40;
    localparam int WIN   = 16;
    localparam int VDL   = 3;
    localparam int ESC   = 5;
    localparam int TLIM  = 20;

    localparam int M_QUIET = 0;
    localparam int M_FLAT  = 1;
    localparam int M_RING  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gate_on = 1'b0;
    logic [TON_W-1:0] ton_cycles = '0;
    logic             fb_above_avs = 1'b0;
    logic             sync_above_hi = 1'b0;
    logic             sync_above_lo = 1'b0;
    logic             sync_above_flat = 1'b0;
    logic             turn_on;

    int    checks = 0;
    int    bad = 0;
    int    gc = 0;
    int    mode = M_QUIET;
    string tag = "R1 R2 R3";
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    qrv_timer #(
        .TON_W (TON_W), .BLANK_CYC (BLK), .WIN_CYC (WIN),
        .VALLEY_DLY (VDL), .ESC_DLY (ESC), .TON_LIM (TLIM), .PAIR_LEN (2)
    ) u_qrv_timer (
        .clk (clk), .rst_n (rst_n), .gate_on (gate_on), .ton_cycles (ton_cycles),
        .fb_above_avs (fb_above_avs), .sync_above_hi (sync_above_hi),
        .sync_above_lo (sync_above_lo), .sync_above_flat (sync_above_flat),
        .turn_on (turn_on)
    );

    // stimulus: sync waveform and gate response, all on the falling edge
    int gate_left = 0;
    always @(negedge clk) begin
        gc = gc + 1;
        case (mode)
            M_FLAT: begin
                sync_above_hi <= 1'b1; sync_above_lo <= 1'b1; sync_above_flat <= 1'b1;
            end
            M_RING: begin
                sync_above_hi   <= ((gc % 8) < 4);
                sync_above_lo   <= ((gc % 8) < 4);
                sync_above_flat <= 1'b0;
            end
            default: begin
                sync_above_hi <= 1'b0; sync_above_lo <= 1'b0; sync_above_flat <= 1'b0;
            end
        endcase
        if (rst_n && turn_on) begin
            gate_on   <= 1'b1;
            gate_left = 3;
        end else if (gate_left > 0) begin
            gate_on   <= 1'b1;
            gate_left = gate_left - 1;
        end else begin
            gate_on <= 1'b0;
        end
    end

    // behavioural reference: timestamps counted from the last gate rise
    int m_since, m_need, m_fire_at, m_n, m_pair;
    bit m_gate_prev, m_armed, m_locked, m_seek, m_done, m_second, m_valley;
    bit exp_on;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_since = 0; m_need = 1; m_fire_at = -1; m_n = 0; m_pair = 0;
            m_gate_prev = 0; m_armed = 0; m_locked = 0; m_seek = 0;
            m_done = 0; m_second = 0; exp_on = 0;
        end else begin
            m_n    = m_n + 1;
            exp_on = 0;
            m_valley = m_armed && !sync_above_lo;
            if (sync_above_hi) m_armed = 1;
            else if (m_valley) m_armed = 0;
            if (gate_on && !m_gate_prev) begin
                bit en;
                en = fb_above_avs && (int'(ton_cycles) < TLIM);
                m_second  = en && (m_pair >= 2);
                m_pair    = en ? (m_pair + 1) % 4 : 0;
                m_since   = 0; m_done = 0; m_seek = 0; m_fire_at = -1;
            end else if (!m_done) begin
                m_since = m_since + 1;
                if (m_since <= BLK) begin
                    if (m_valley) m_locked = 1;
                    if (m_since == BLK) begin
                        if (!m_locked && sync_above_flat) m_fire_at = m_n + ESC;
                        else begin m_seek = 1; m_need = m_second ? 2 : 1; end
                    end
                end else if (m_seek) begin
                    if (m_valley && m_need == 1) begin
                        m_seek = 0; m_fire_at = m_n + VDL;
                    end else begin
                        if (m_valley) m_need = m_need - 1;
                        if (m_since == BLK + WIN) begin
                            exp_on = 1; m_done = 1; m_seek = 0;
                        end
                    end
                end else if (m_fire_at == m_n) begin
                    exp_on = 1; m_done = 1;
                end
            end
            m_gate_prev = gate_on;
        end
    end

    // clock-by-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks = checks + 1;
            if (turn_on !== exp_on) begin
                bad = bad + 1;
                $display("FAIL %s turn_on actual=%0b expected=%0b cycle=%0d", tag, turn_on, exp_on, gc);
            end
        end
    end

    int last_pulse = 0;
    task automatic wait_pulse(output int gap);
        do @(negedge clk); while (turn_on !== 1'b1);
        gap = gc - last_pulse;
        last_pulse = gc;
    endtask

    task automatic run_phase(input int md, input bit fb, input int ton, input int k,
                             input int exp_gap, input string t);
        int gap;
        mode = md; fb_above_avs = fb; ton_cycles = TON_W'(ton); tag = t;
        for (int i = 0; i < k; i++) begin
            wait_pulse(gap);
            if (exp_gap > 0) begin
                checks = checks + 1;
                if (gap != exp_gap) begin
                    bad = bad + 1;
                    $display("FAIL %s pulse spacing actual=%0d expected=%0d", t, gap, exp_gap);
                end
            end
        end
    endtask

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        // R1: request low under reset
        checks = checks + 1;
        if (turn_on !== 1'b0) begin
            bad = bad + 1;
            $display("FAIL R1 reset turn_on actual=%0b expected=0", turn_on);
        end
        rst_n = 1'b1;
        last_pulse = gc;
        wait_pulse(gap);
        // R1 R3: first request forced blanking plus window after reset
        checks = checks + 1;
        if (gap != BLK + WIN) begin
            bad = bad + 1;
            $display("FAIL R1 first request actual=%0d expected=%0d", gap, BLK + WIN);
        end
        run_phase(M_QUIET, 0, 50, 4, 1 + BLK + WIN, "R2 R3 R10");
        run_phase(M_FLAT,  0, 50, 4, 1 + BLK + ESC, "R5");
        run_phase(M_RING,  0, 50, 6, 0, "R4 R6");
        run_phase(M_FLAT,  0, 50, 3, 1 + BLK + WIN, "R6");
        run_phase(M_RING,  1, 10, 9, 0, "R7 R8");
        run_phase(M_RING,  1, 30, 3, 0, "R7 R9");
        run_phase(M_RING,  1, 10, 5, 0, "R8 R9");
        run_phase(M_RING,  0, 10, 3, 0, "R7");
        run_phase(M_QUIET, 1, 10, 2, 0, "R3 R8");
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks = checks + 1;
            bad = bad + 1;
            $display("FAIL watchdog run did not end actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule